// File: doc/BRIEF.md
# Local Interrupt Priority Arbiter

This block holds every interrupt waiting for one processor core and chooses which one the core sees next. It tracks three unmaskable request kinds: system-management, non-maskable and init. It also tracks one external request and a pair of 256-bit arrays for ordinary vectored interrupts. The first array marks requested vectors. The second marks vectors that are in service.

From the core it takes an interrupt-enable flag, a task-priority value and an acknowledge strobe. It presents three outputs: a pending flag, a kind code and an 8-bit vector. When the core acknowledges, the block retires the request it was presenting. For an ordinary vector, that means moving the vector from the request array into the in-service array. An end-of-interrupt pulse retires the highest in-service vector.

The outputs depend combinationally on the registered state and on the enable and task-priority inputs. A request input takes effect on the clock edge where it is sampled.

Top module: `lirq_arbiter`

## Requirements
- R1: Whenever a system-management, non-maskable or init request is outstanding, `pend` is high, whatever the value of `irq_en`.
- R2: With `irq_en` low, an outstanding external or ordinary request never makes `pend` high.
- R3: An ordinary vector is deliverable only when all of the following hold: the highest requested vector is numerically above the highest in-service vector, and its bits 7:4 exceed bits 7:4 of `task_prio`. An empty array reads as vector 0.
- R4: Among the unmaskable kinds, system-management wins over non-maskable, which wins over init.
- R5: Any unmaskable kind wins over the external request, and the external request wins over an ordinary vector.
- R6: The vector shown depends on the kind:
  - non-maskable, init and external show the vector captured with their most recent request;
  - ordinary shows the highest requested vector;
  - system-management and none show 0.
- R7: Acknowledging an unmaskable or external kind clears only that kind's pending flag.
- R8: Acknowledging an ordinary vector does three things: it clears that vector's request bit, sets its in-service bit, and makes it the highest in-service vector.
- R9: An `eoi` pulse clears only the highest set in-service bit, and the highest in-service vector is recomputed from the bits that remain.
- R10: A new request that arrives in the same cycle as an acknowledge of the same kind, or of the same vector, stays pending. An external or unmaskable request that arrives this way also updates the captured vector.
- R11: `kind` is encoded as 0 none, 1 system-management, 2 non-maskable, 3 init, 4 external, 5 ordinary. `ack` while `pend` is low changes no state.
- R12: After reset nothing is pending, both arrays are empty, and `kind` and `vec_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Interrupt-enable flag of the core |
| task_prio | input | 8 | Task-priority value; bits 7:4 form the class |
| sysmgt_req | input | 1 | System-management request pulse |
| nomask_req | input | 1 | Non-maskable request pulse |
| nomask_vec | input | 8 | Vector captured with the non-maskable request |
| init_req | input | 1 | Init request pulse |
| init_vec | input | 8 | Vector captured with the init request |
| ext_req | input | 1 | External request pulse |
| ext_vec | input | 8 | Vector captured with the external request |
| vec_req | input | 1 | Ordinary request pulse |
| vec_num | input | 8 | Vector number of the ordinary request |
| ack | input | 1 | Core accepts the presented interrupt |
| eoi | input | 1 | End-of-interrupt pulse |
| pend | output | 1 | An interrupt is presented |
| kind | output | 3 | Kind of the presented interrupt (R11 encoding) |
| vec_out | output | 8 | Vector of the presented interrupt |

## Verification
The bench targets these corner cases:

- A task-priority class equal to the request's class must block delivery. A design that compares with greater-or-equal would deliver there.
- After an ordinary acknowledge, a lower vector must stay blocked until end-of-interrupt. A design that never tracks the in-service vector would deliver it at once.
- End-of-interrupt is driven with two vectors in service. A design that clears the lowest bit, or clears all bits, shows the wrong vector or nothing afterwards.
- A request coincides with the acknowledge of the same kind or vector. A design that lets the clear win drops that request.
- All unmaskable kinds are raised together and then acknowledged one at a time. A design with the order swapped, or one that clears every flag at once, exposes itself.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_SYSMGT = 3'd1,
    K_NOMASK = 3'd2,
    K_INIT   = 3'd3,
    K_EXT    = 3'd4,
    K_VEC    = 3'd5
  } kind_e;

  // slot indices of the flag-plus-vector holders, in priority order
  localparam int SLOT_SYSMGT = 0;
  localparam int SLOT_NOMASK = 1;
  localparam int SLOT_INIT   = 2;
  localparam int SLOT_EXT    = 3;
  localparam int NSLOT       = 4;

endpackage

// File: rtl/lirq_rst_sync.sv
module lirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sh_q[STAGES-1];
endmodule

// File: rtl/lirq_prienc.sv
module lirq_prienc #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_bits,
  output logic [W-1:0] idx,
  output logic         any
);
  // highest set bit wins; empty input gives index 0
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_bits[i]) begin
        idx = W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lirq_slot.sv
module lirq_slot #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [VW-1:0] set_vec,
  input  logic          clr,
  output logic          flag,
  output logic [VW-1:0] vec
);
  logic          flag_q, flag_n, flag_en;
  logic [VW-1:0] vec_q;

  // a set in the same cycle as a clear keeps the flag
  always_comb begin
    flag_en = set | clr;
    flag_n  = (flag_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (flag_en) flag_q <= flag_n;
      if (set)     vec_q  <= set_vec;
    end
  end

  assign flag = flag_q;
  assign vec  = vec_q;
endmodule

// File: rtl/lirq_vecbank.sv
module lirq_vecbank #(
  parameter int NVEC = 256,
  parameter int VW   = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [VW-1:0] set_vec,
  input  logic          take,
  input  logic          eoi,
  output logic [VW-1:0] req_top,
  output logic          req_any,
  output logic [VW-1:0] svc_top,
  output logic          svc_any
);
  logic [NVEC-1:0] req_q, req_n, svc_q, svc_n;
  logic            req_en, svc_en;

  lirq_prienc #(.N(NVEC), .W(VW)) u_req_enc (
    .req_bits(req_q), .idx(req_top), .any(req_any));

  lirq_prienc #(.N(NVEC), .W(VW)) u_svc_enc (
    .req_bits(svc_q), .idx(svc_top), .any(svc_any));

  always_comb begin
    req_en = set | take;
    svc_en = take | eoi;
    req_n  = req_q;
    svc_n  = svc_q;
    // request side: taking clears, a fresh set wins
    if (take) req_n[req_top] = 1'b0;
    if (set)  req_n[set_vec] = 1'b1;
    // service side: end-of-interrupt retires the top bit only
    if (eoi && svc_any) svc_n[svc_top] = 1'b0;
    if (take)           svc_n[req_top] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      svc_q <= '0;
    end else begin
      if (req_en) req_q <= req_n;
      if (svc_en) svc_q <= svc_n;
    end
  end
endmodule

// File: rtl/lirq_arbiter.sv
module lirq_arbiter
  import lirq_pkg::*;
#(
  parameter int NVEC  = 256,
  parameter int VW    = $clog2(NVEC),
  parameter int CLS_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_en,
  input  logic [VW-1:0] task_prio,
  input  logic          sysmgt_req,
  input  logic          nomask_req,
  input  logic [VW-1:0] nomask_vec,
  input  logic          init_req,
  input  logic [VW-1:0] init_vec,
  input  logic          ext_req,
  input  logic [VW-1:0] ext_vec,
  input  logic          vec_req,
  input  logic [VW-1:0] vec_num,
  input  logic          ack,
  input  logic          eoi,
  output logic          pend,
  output logic [2:0]    kind,
  output logic [VW-1:0] vec_out
);
  localparam int CLS_LO = VW - CLS_W;

  logic rst_s;

  logic [NSLOT-1:0]  slot_set, slot_clr, slot_flag;
  logic [VW-1:0]     slot_vin [NSLOT];
  logic [VW-1:0]     slot_vq  [NSLOT];

  logic [VW-1:0] req_top, svc_top;
  logic          req_any, svc_any;
  logic          unmask_any, vec_ok, take_vec, ack_ok;
  kind_e         kind_sel;

  lirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  always_comb begin
    slot_set[SLOT_SYSMGT] = sysmgt_req;
    slot_set[SLOT_NOMASK] = nomask_req;
    slot_set[SLOT_INIT]   = init_req;
    slot_set[SLOT_EXT]    = ext_req;
    slot_vin[SLOT_SYSMGT] = '0;
    slot_vin[SLOT_NOMASK] = nomask_vec;
    slot_vin[SLOT_INIT]   = init_vec;
    slot_vin[SLOT_EXT]    = ext_vec;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    lirq_slot #(.VW(VW)) u_slot (
      .clk(clk), .rst_n(rst_s),
      .set(slot_set[g]), .set_vec(slot_vin[g]), .clr(slot_clr[g]),
      .flag(slot_flag[g]), .vec(slot_vq[g]));
  end

  lirq_vecbank #(.NVEC(NVEC), .VW(VW)) u_bank (
    .clk(clk), .rst_n(rst_s),
    .set(vec_req), .set_vec(vec_num),
    .take(take_vec), .eoi(eoi),
    .req_top(req_top), .req_any(req_any),
    .svc_top(svc_top), .svc_any(svc_any));

  // selection: fixed priority, enable gates only external and ordinary
  always_comb begin
    unmask_any = slot_flag[SLOT_SYSMGT] | slot_flag[SLOT_NOMASK] |
                 slot_flag[SLOT_INIT];
    vec_ok = req_any && (req_top > svc_top) &&
             (req_top[VW-1:CLS_LO] > task_prio[VW-1:CLS_LO]);
    if      (slot_flag[SLOT_SYSMGT])          kind_sel = K_SYSMGT;
    else if (slot_flag[SLOT_NOMASK])          kind_sel = K_NOMASK;
    else if (slot_flag[SLOT_INIT])            kind_sel = K_INIT;
    else if (irq_en && slot_flag[SLOT_EXT])   kind_sel = K_EXT;
    else if (irq_en && vec_ok)                kind_sel = K_VEC;
    else                                      kind_sel = K_NONE;
  end

  always_comb begin
    unique case (kind_sel)
      K_SYSMGT: vec_out = slot_vq[SLOT_SYSMGT];
      K_NOMASK: vec_out = slot_vq[SLOT_NOMASK];
      K_INIT:   vec_out = slot_vq[SLOT_INIT];
      K_EXT:    vec_out = slot_vq[SLOT_EXT];
      K_VEC:    vec_out = req_top;
      default:  vec_out = '0;
    endcase
  end

  // retire exactly what is presented
  always_comb begin
    ack_ok   = ack && (kind_sel != K_NONE);
    slot_clr = '0;
    slot_clr[SLOT_SYSMGT] = ack_ok && (kind_sel == K_SYSMGT);
    slot_clr[SLOT_NOMASK] = ack_ok && (kind_sel == K_NOMASK);
    slot_clr[SLOT_INIT]   = ack_ok && (kind_sel == K_INIT);
    slot_clr[SLOT_EXT]    = ack_ok && (kind_sel == K_EXT);
    take_vec = ack_ok && (kind_sel == K_VEC);
  end

  assign pend = (kind_sel != K_NONE);
  assign kind = kind_sel;

endmodule

// File: rtl/lirq_arbiter_chk.sv
module lirq_arbiter_chk #(
  parameter int VW    = 8,
  parameter int CLS_W = 4
) (
  input logic          clk,
  input logic          rst_s,
  input logic          irq_en,
  input logic [VW-1:0] task_prio,
  input logic          sysmgt_req,
  input logic          nomask_req,
  input logic          init_req,
  input logic          vec_req,
  input logic [VW-1:0] vec_num,
  input logic          ack,
  input logic          eoi,
  input logic          pend,
  input logic [2:0]    kind,
  input logic [VW-1:0] vec_out,
  input logic [VW-1:0] svc_top,
  input logic [VW-1:0] req_top
);
  localparam int CLS_LO = VW - CLS_W;

  // R1
  unmask_pend_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (sysmgt_req || nomask_req || init_req) |=> pend);

  // R2
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !irq_en |-> (kind != 3'd4 && kind != 3'd5));

  // R3
  class_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (kind == 3'd5) |-> (vec_out[VW-1:CLS_LO] > task_prio[VW-1:CLS_LO]
                        && vec_out > svc_top));

  // R7
  sysmgt_retire_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ack && kind == 3'd1 && !sysmgt_req) |=> (kind != 3'd1));

  // R8
  vec_retire_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ack && kind == 3'd5 && !eoi) |=> (svc_top == $past(vec_out)));

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ack && !pend && !eoi && !vec_req) |=> ($stable(svc_top) && $stable(req_top)));

  // R11
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (kind <= 3'd5) && (pend == (kind != 3'd0)));

  // R10
  same_vec_keep_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (ack && kind == 3'd5 && vec_req && vec_num == vec_out) |=> (req_top == $past(vec_out)));
endmodule

bind lirq_arbiter lirq_arbiter_chk #(.VW(VW), .CLS_W(CLS_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .irq_en(irq_en), .task_prio(task_prio),
  .sysmgt_req(sysmgt_req), .nomask_req(nomask_req), .init_req(init_req),
  .vec_req(vec_req), .vec_num(vec_num), .ack(ack), .eoi(eoi),
  .pend(pend), .kind(kind), .vec_out(vec_out),
  .svc_top(svc_top), .req_top(req_top));

// File: tb/lirq_arbiter_test.sv
module lirq_arbiter_test;
  localparam int PER = 10;

  logic       clk, rst_n, irq_en;
  logic [7:0] task_prio, nomask_vec, init_vec, ext_vec, vec_num;
  logic       sysmgt_req, nomask_req, init_req, ext_req, vec_req, ack, eoi;
  logic       pend;
  logic [2:0] kind;
  logic [7:0] vec_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic       p;
    logic [2:0] k;
    logic [7:0] v;
    string      tag;
  } exp_t;

  exp_t sb[$];

  lirq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .task_prio(task_prio),
    .sysmgt_req(sysmgt_req), .nomask_req(nomask_req), .nomask_vec(nomask_vec),
    .init_req(init_req), .init_vec(init_vec), .ext_req(ext_req), .ext_vec(ext_vec),
    .vec_req(vec_req), .vec_num(vec_num), .ack(ack), .eoi(eoi),
    .pend(pend), .kind(kind), .vec_out(vec_out));

  initial clk = 1'b0;
  always #(PER/2) clk = ~clk;

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      exp_t it;
      wait (sb.size() != 0);
      #1;
      it = sb.pop_front();
      total++;
      if (pend !== it.p || kind !== it.k || vec_out !== it.v) begin
        bad++;
        $display("FAIL %s: got pend=%0b kind=%0d vec=%h, want pend=%0b kind=%0d vec=%h",
                 it.tag, pend, kind, vec_out, it.p, it.k, it.v);
      end
    end
  end

  task automatic want(input logic [2:0] k, input logic [7:0] v, input string tag);
    exp_t it;
    it.p = (k != 3'd0); it.k = k; it.v = v; it.tag = tag;
    sb.push_back(it);
    #2;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    sysmgt_req = 0; nomask_req = 0; init_req = 0; ext_req = 0;
    vec_req = 0; ack = 0; eoi = 0;
    @(negedge clk);
  endtask

  task automatic post(input logic [7:0] v);
    vec_req = 1; vec_num = v; tick();
  endtask

  initial begin
    #(PER*20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_en = 0; task_prio = 0;
    sysmgt_req = 0; nomask_req = 0; init_req = 0; ext_req = 0;
    vec_req = 0; ack = 0; eoi = 0;
    nomask_vec = 0; init_vec = 0; ext_vec = 0; vec_num = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) tick();
    want(0, 8'h00, "R12 reset");

    // enable gating and ignored acknowledge
    post(8'h35);
    want(0, 8'h00, "R2 ordinary masked");
    ack = 1; tick();
    irq_en = 1;
    want(5, 8'h35, "R11 idle ack ignored");

    // task-priority class
    task_prio = 8'h40; want(0, 8'h00, "R3 class above");
    task_prio = 8'h30; want(0, 8'h00, "R3 class equal");
    task_prio = 8'h2F; want(5, 8'h35, "R3 class below");

    // in-service blocking and end-of-interrupt
    post(8'h80);
    want(5, 8'h80, "R6 highest requested");
    ack = 1; tick();
    want(0, 8'h00, "R8 lower blocked");
    eoi = 1; tick();
    want(5, 8'h35, "R9 eoi unblocks");
    ack = 1; tick();
    task_prio = 8'h00;
    post(8'h20);
    want(0, 8'h00, "R8 below in-service");
    eoi = 1; tick();
    want(5, 8'h20, "R9 service empty");
    ack = 1; tick(); eoi = 1; tick();
    want(0, 8'h00, "R8 arrays drained");

    // eoi retires only the top in-service bit
    post(8'h40); ack = 1; tick();
    post(8'h90);
    want(5, 8'h90, "R3 above in-service");
    ack = 1; tick();
    post(8'h60);
    want(0, 8'h00, "R8 blocked by 0x90");
    eoi = 1; tick();
    want(5, 8'h60, "R9 top bit only");
    ack = 1; tick(); eoi = 1; tick(); eoi = 1; tick();
    want(0, 8'h00, "R9 drained");

    // external versus ordinary
    vec_req = 1; vec_num = 8'h70; ext_req = 1; ext_vec = 8'h21; tick();
    want(4, 8'h21, "R5 external over ordinary");
    irq_en = 0; want(0, 8'h00, "R2 external masked");
    irq_en = 1; ack = 1; tick();
    want(5, 8'h70, "R7 external retired");
    ack = 1; tick(); eoi = 1; tick();

    // unmaskable ordering
    irq_en = 0;
    sysmgt_req = 1; nomask_req = 1; nomask_vec = 8'h22;
    init_req = 1; init_vec = 8'h11; tick();
    want(1, 8'h00, "R1 R4 system-management first");
    ack = 1; tick();
    want(2, 8'h22, "R4 non-maskable second");
    ack = 1; tick();
    want(3, 8'h11, "R6 init vector");
    ack = 1; tick();
    want(0, 8'h00, "R7 all retired");

    // unmaskable over external over ordinary
    irq_en = 1;
    ext_req = 1; ext_vec = 8'h33; nomask_req = 1; nomask_vec = 8'h44;
    vec_req = 1; vec_num = 8'h50; tick();
    want(2, 8'h44, "R5 unmaskable first");
    ack = 1; tick();
    want(4, 8'h33, "R5 external next");
    ack = 1; tick();
    want(5, 8'h50, "R5 ordinary last");
    ack = 1; tick(); eoi = 1; tick();

    // same-cycle request and acknowledge
    nomask_req = 1; nomask_vec = 8'h55; tick();
    want(2, 8'h55, "R6 captured vector");
    ack = 1; nomask_req = 1; nomask_vec = 8'h66; tick();
    want(2, 8'h66, "R10 unmaskable kept");
    ack = 1; tick();
    want(0, 8'h00, "R7 non-maskable retired");
    post(8'h90);
    want(5, 8'h90, "R3 ordinary 0x90");
    ack = 1; vec_req = 1; vec_num = 8'h90; tick();
    want(0, 8'h00, "R10 blocked by own service");
    eoi = 1; tick();
    want(5, 8'h90, "R10 vector kept");
    ack = 1; tick(); eoi = 1; tick();

    // class zero cannot beat class zero
    post(8'h05);
    want(0, 8'h00, "R3 class zero");

    wait (sb.size() == 0);
    #3;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule